// File: doc/BRIEF.md
# Accumulator Condition Skip Unit

This unit executes the register-test instruction group of a 12-bit accumulator processor. Each strobed instruction word is decoded against two main accumulators (called J and K here), an overflow bit and a flag bit. The unit returns the updated values of all four and a skip request. A skip request tells the sequencer to advance the program counter by one extra word. The sequencer owns the registers: it presents the current values on the inputs and loads the outputs back one clock later.

Two subgroups share one encoding space. The two accumulator-select bits pick the subgroup. When either bit is set, the low field tests, clears, complements, sets or increments the selected accumulators. When both are clear, the same field works on the overflow bit or the flag bit. When both accumulators are selected, the zero test, the sign tests and the nonzero test each fold the two per-register results with their own rule.

Top module: `cskip_unit`

## Requirements
- R1: While `rst` is high and at the first edge after it, `j_out`, `k_out`, `ovf_out`, `flag_out` and `skip` are all zero.
- R2: A word belongs to the group only when bits 11:8 equal binary 0011. Bit 7 selects K and bit 6 selects J. A strobed word outside the group returns all four input values unchanged with no skip.
- R3: Accumulator subgroup, low bits 2:0 = 101: skip if the selected register is zero, or if both selected registers are zero. Low bits 2:0 = 001: skip if the selected register is nonzero, or if either selected register is nonzero.
- R4: Accumulator subgroup, low bits 2:0 = 010: skip if the sign bit (bit 11) is clear, so zero counts as positive. Low bits 2:0 = 110: skip if the sign bit is set. With both registers selected, both must meet the test. Low bits 1:0 = 11 never skip.
- R5: Accumulator subgroup, low bits 4:3 = 01 clears, 10 complements and 11 sets to all ones. Only the selected accumulators change, and the overflow and flag bits pass through.
- R6: Accumulator subgroup, low bits 2:0 = 100 add one modulo 4096 after the bits 4:3 operation. Complement followed by increment (low field 010100) therefore negates.
- R7: Status subgroup (bits 7:6 = 00): bit 5 picks overflow (1) or flag (0). Bits 4:3 clear, complement or set the picked bit as in R5. Low bits 2:0 = 001 skip if it is set, and 101 skip if it is clear. J and K pass through.
- R8: Status subgroup, low bits 1:0 = 10 skip unconditionally. Other low codes, such as the idle word 001 100 000 000, do not skip.
- R9: Every skip test looks at the values from before the same instruction's update. The skip and the updated values appear together on the clock edge that samples the strobe.
- R10: With `instr_valid` low, the outputs hold their last values and `skip` stays low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 12 | Instruction word |
| j_in | input | 12 | Current J accumulator |
| k_in | input | 12 | Current K accumulator |
| ovf_in | input | 1 | Current overflow bit |
| flag_in | input | 1 | Current flag bit |
| j_out | output | 12 | Updated J accumulator |
| k_out | output | 12 | Updated K accumulator |
| ovf_out | output | 1 | Updated overflow bit |
| flag_out | output | 1 | Updated flag bit |
| skip | output | 1 | One-cycle skip request |

## Verification
Every one of the 4096 instruction words is applied against eight register tuples. The tuples cover zero and nonzero values, each sign, the most-positive and most-negative values, and all ones (which wraps on increment). Mixed tuples, where J and K disagree on zero or sign, are what show the AND fold of the zero and sign tests apart from the OR fold of the nonzero test. The overflow and flag bits take all four combinations across the tuples, which separates the set, clear and complement paths and shows which status bit the test read. After each instruction the inputs are scrambled with the strobe low, to show that the registered outputs hold.

// File: rtl/cskip_pkg.sv
package cskip_pkg;

  typedef enum logic [1:0] {
    MOD_KEEP   = 2'b00,
    MOD_CLEAR  = 2'b01,
    MOD_INVERT = 2'b10,
    MOD_ONES   = 2'b11
  } mod_e;

  typedef enum logic [1:0] {
    TST_NONE = 2'b00,
    TST_ZERO = 2'b01,
    TST_SIGN = 2'b10,
    TST_RSVD = 2'b11
  } tst_e;

  typedef struct packed {
    logic in_group;
    logic sel_k;
    logic sel_j;
    logic status_grp;
    logic pick_ovf;
    mod_e modify;
    logic incr;
    tst_e test;
    logic flip;
  } dec_t;

endpackage

// File: rtl/cskip_decode.sv
module cskip_decode
  import cskip_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] instr,
  output dec_t              dec
);
  localparam int OPC_LSB = WORD_W - 4;
  localparam logic [3:0] GROUP_CODE = 4'b0011;

  logic [5:0] low;
  logic       grp;

  assign low = instr[5:0];
  assign grp = (instr[WORD_W-1:OPC_LSB] == GROUP_CODE);

  always_comb begin
    dec.in_group   = grp;
    dec.sel_k      = grp & instr[OPC_LSB-1];
    dec.sel_j      = grp & instr[OPC_LSB-2];
    dec.status_grp = grp & ~instr[OPC_LSB-1] & ~instr[OPC_LSB-2];
    dec.pick_ovf   = low[5];
    dec.modify     = mod_e'(low[4:3]);
    dec.test       = tst_e'(low[1:0]);
    dec.flip       = low[2];
    dec.incr       = (low[2:0] == 3'b100);
  end
endmodule

// File: rtl/cskip_acc_lane.sv
module cskip_acc_lane
  import cskip_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] val_in,
  input  logic              sel,
  input  mod_e              modify,
  input  logic              incr,
  input  tst_e              test,
  input  logic              flip,
  output logic [WORD_W-1:0] val_out,
  output logic              cond
);
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] mod_v;

  always_comb begin
    unique case (modify)
      MOD_CLEAR:  mod_v = '0;
      MOD_INVERT: mod_v = ~val_in;
      MOD_ONES:   mod_v = '1;
      default:    mod_v = val_in;
    endcase
    if (!sel)       val_out = val_in;
    else if (incr)  val_out = mod_v + ONE;
    else            val_out = mod_v;
  end

  always_comb begin
    unique case (test)
      TST_ZERO: cond = flip ? (val_in == '0) : (val_in != '0);
      TST_SIGN: cond = flip ? val_in[WORD_W-1] : ~val_in[WORD_W-1];
      default:  cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/cskip_status_bit.sv
module cskip_status_bit
  import cskip_pkg::*;
(
  input  logic bit_in,
  input  logic sel,
  input  mod_e modify,
  input  logic flip,
  output logic bit_out,
  output logic cond
);
  always_comb begin
    if (!sel) bit_out = bit_in;
    else begin
      unique case (modify)
        MOD_CLEAR:  bit_out = 1'b0;
        MOD_INVERT: bit_out = ~bit_in;
        MOD_ONES:   bit_out = 1'b1;
        default:    bit_out = bit_in;
      endcase
    end
    cond = sel & (flip ? ~bit_in : bit_in);
  end
endmodule

// File: rtl/cskip_unit.sv
module cskip_unit
  import cskip_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] j_in,
  input  logic [WORD_W-1:0] k_in,
  input  logic              ovf_in,
  input  logic              flag_in,
  output logic [WORD_W-1:0] j_out,
  output logic [WORD_W-1:0] k_out,
  output logic              ovf_out,
  output logic              flag_out,
  output logic              skip
);
  localparam int LANES = 2;
  localparam int STBITS = 2;

  dec_t dec;

  cskip_decode #(.WORD_W(WORD_W)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  logic [WORD_W-1:0] acc_in [LANES];
  logic [WORD_W-1:0] acc_nx [LANES];
  logic [LANES-1:0]  acc_sel;
  logic [LANES-1:0]  acc_cond;

  assign acc_in[0] = j_in;
  assign acc_in[1] = k_in;
  assign acc_sel   = {dec.sel_k, dec.sel_j};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cskip_acc_lane #(.WORD_W(WORD_W)) u_lane (
      .val_in  (acc_in[g]),
      .sel     (acc_sel[g]),
      .modify  (dec.modify),
      .incr    (dec.incr),
      .test    (dec.test),
      .flip    (dec.flip),
      .val_out (acc_nx[g]),
      .cond    (acc_cond[g])
    );
  end

  // index 0 = flag, index 1 = overflow
  logic [STBITS-1:0] st_in, st_nx, st_sel, st_cond;

  assign st_in = {ovf_in, flag_in};

  for (genvar s = 0; s < STBITS; s++) begin : g_stat
    assign st_sel[s] = dec.status_grp & (dec.pick_ovf == (s == 1));
    cskip_status_bit u_bit (
      .bit_in  (st_in[s]),
      .sel     (st_sel[s]),
      .modify  (dec.modify),
      .flip    (dec.flip),
      .bit_out (st_nx[s]),
      .cond    (st_cond[s])
    );
  end

  logic any_hit, all_hit, acc_skip, st_skip;

  always_comb begin
    any_hit  = |(acc_sel & acc_cond);
    all_hit  = &(~acc_sel | acc_cond);
    acc_skip = 1'b0;
    if (|acc_sel) begin
      unique case (dec.test)
        TST_ZERO: acc_skip = dec.flip ? all_hit : any_hit;
        TST_SIGN: acc_skip = all_hit;
        default:  acc_skip = 1'b0;
      endcase
    end
    st_skip = dec.status_grp &
              (((dec.test == TST_ZERO) & (|st_cond)) | (dec.test == TST_SIGN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      j_out    <= '0;
      k_out    <= '0;
      ovf_out  <= 1'b0;
      flag_out <= 1'b0;
      skip     <= 1'b0;
    end else if (instr_valid) begin
      j_out    <= acc_nx[0];
      k_out    <= acc_nx[1];
      ovf_out  <= st_nx[1];
      flag_out <= st_nx[0];
      skip     <= acc_skip | st_skip;
    end else begin
      skip     <= 1'b0;
    end
  end
endmodule

// File: rtl/cskip_unit_chk.sv
module cskip_unit_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] j_in,
  input logic [WORD_W-1:0] k_in,
  input logic              ovf_in,
  input logic              flag_in,
  input logic [WORD_W-1:0] j_out,
  input logic [WORD_W-1:0] k_out,
  input logic              ovf_out,
  input logic              flag_out,
  input logic              skip
);
  localparam logic [3:0] GROUP_CODE = 4'b0011;

  logic grp_now, status_now;
  assign grp_now    = (instr[WORD_W-1 -: 4] == GROUP_CODE);
  assign status_now = grp_now & (instr[WORD_W-5 -: 2] == 2'b00);

  assert_skip_strobed_R10: assert property (@(posedge clk) disable iff (rst)
    skip |-> $past(instr_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(instr_valid) |-> ($stable(j_out) && $stable(k_out) &&
                             $stable(ovf_out) && $stable(flag_out)));

  assert_foreign_passes_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_valid) && !$past(grp_now)) |->
      (j_out == $past(j_in) && k_out == $past(k_in) &&
       ovf_out == $past(ovf_in) && flag_out == $past(flag_in) && !skip));

  assert_status_untouched_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_valid) && $past(grp_now) && !$past(status_now)) |->
      (ovf_out == $past(ovf_in) && flag_out == $past(flag_in)));

  assert_acc_untouched_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_valid) && $past(status_now)) |->
      (j_out == $past(j_in) && k_out == $past(k_in)));

  assert_uncond_skip_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_valid) && $past(status_now) && $past(instr[1:0]) == 2'b10) |-> skip);
endmodule

bind cskip_unit cskip_unit_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_cskip_unit.sv
module tb_cskip_unit;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instr_valid = 1'b0;
  logic [W-1:0] instr = '0;
  logic [W-1:0] j_in = '0, k_in = '0;
  logic         ovf_in = 1'b0, flag_in = 1'b0;
  logic [W-1:0] j_out, k_out;
  logic         ovf_out, flag_out, skip;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cskip_unit #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .j_in(j_in), .k_in(k_in), .ovf_in(ovf_in), .flag_in(flag_in),
    .j_out(j_out), .k_out(k_out), .ovf_out(ovf_out), .flag_out(flag_out),
    .skip(skip)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h instr=%04o", tag, what, act, exp, instr);
    end
  endtask

  function automatic logic [W-1:0] modv(input logic [W-1:0] v, input logic [5:0] lo);
    logic [W-1:0] r;
    case (lo[4:3])
      2'b01: r = 0;
      2'b10: r = ~v;
      2'b11: r = {W{1'b1}};
      default: r = v;
    endcase
    if (lo[2:0] == 3'b100) r = r + 1;
    return r;
  endfunction

  function automatic logic modb(input logic b, input logic [5:0] lo);
    case (lo[4:3])
      2'b01: return 1'b0;
      2'b10: return ~b;
      2'b11: return 1'b1;
      default: return b;
    endcase
  endfunction

  logic [W-1:0] ej, ek;
  logic eo, ef, es;
  string tag_val, tag_skip;

  task automatic model(input logic [W-1:0] ins, input logic [W-1:0] j, input logic [W-1:0] k,
                       input logic o, input logic f);
    logic grp, sk, sj;
    logic [5:0] lo;
    logic jz, kz, jn, kn;
    grp = (ins[11:8] == 4'b0011);
    sk = ins[7]; sj = ins[6]; lo = ins[5:0];
    ej = j; ek = k; eo = o; ef = f; es = 1'b0;
    tag_val = "R2"; tag_skip = "R2";
    jz = (j == 0); kz = (k == 0); jn = j[W-1]; kn = k[W-1];
    if (grp && (sk || sj)) begin
      tag_val = (lo[2:0] == 3'b100) ? "R6" : "R5";
      if (sj) ej = modv(j, lo);
      if (sk) ek = modv(k, lo);
      case (lo[2:0])
        3'b101: es = (!sj || jz) && (!sk || kz);   // R3 both zero
        3'b001: es = (sj && !jz) || (sk && !kz);   // R3 either nonzero
        3'b010: es = (!sj || !jn) && (!sk || !kn); // R4 positive
        3'b110: es = (!sj || jn) && (!sk || kn);   // R4 negative
        default: es = 1'b0;
      endcase
      tag_skip = (lo[1:0] == 2'b10) ? "R4" : "R3";
      if (lo[4:3] != 2'b00 && lo[1:0] != 2'b00) tag_skip = "R9";
    end else if (grp) begin
      tag_val = "R7";
      if (lo[5]) eo = modb(o, lo); else ef = modb(f, lo);
      if (lo[1:0] == 2'b10) begin es = 1'b1; tag_skip = "R8"; end
      else if (lo[1:0] == 2'b01) begin
        es = lo[2] ? !(lo[5] ? o : f) : (lo[5] ? o : f);
        tag_skip = "R7";
      end else tag_skip = "R8";
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] tj [8] = '{12'h000, 12'h000, 12'hFFF, 12'h7FF, 12'h800, 12'h001, 12'h5A5, 12'hFFF};
    logic [W-1:0] tk [8] = '{12'h000, 12'h001, 12'h000, 12'h800, 12'h800, 12'h7FF, 12'hFFF, 12'hFFF};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "j_out", int'(j_out), 0);
    chk("R1", "k_out", int'(k_out), 0);
    chk("R1", "ovf_out", int'(ovf_out), 0);
    chk("R1", "flag_out", int'(flag_out), 0);
    chk("R1", "skip", int'(skip), 0);
    rst = 1'b0;
    for (int t = 0; t < 8; t++) begin
      for (int w = 0; w < 4096; w++) begin
        @(negedge clk);
        instr = w[W-1:0];
        j_in = tj[t]; k_in = tk[t];
        ovf_in = t[0]; flag_in = t[1];
        model(instr, j_in, k_in, ovf_in, flag_in);
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(tag_val, "j_out", int'(j_out), int'(ej));
        chk(tag_val, "k_out", int'(k_out), int'(ek));
        chk(tag_val, "ovf_out", int'(ovf_out), int'(eo));
        chk(tag_val, "flag_out", int'(flag_out), int'(ef));
        chk(tag_skip, "skip", int'(skip), int'(es));
        // R10: scramble inputs with the strobe low, outputs must hold
        j_in = ~j_in; k_in = ~k_in; ovf_in = ~ovf_in; flag_in = ~flag_in;
        instr = 12'o1430;
        @(negedge clk);
        chk("R10", "hold j_out", int'(j_out), int'(ej));
        chk("R10", "hold flag_out", int'(flag_out), int'(ef));
        chk("R10", "hold skip", int'(skip), 0);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule